// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of words by a fixed number of cycles. It does not push every word through a chain of flip-flops. Samples stay where they are written in a two-port storage array, and two address counters walk around it instead. On every enabled cycle the write port stores the incoming word at the write pointer. In the same cycle the read port fetches the word at the read pointer into a registered output. Both pointers then move forward by one. The depth of the array, a power of two, sets the delay.

Reset places the read pointer on the first entry and the write pointer on the last entry. From then on the write pointer always trails the read pointer by exactly one location. A word therefore becomes readable one full lap after it was stored. The output stays at zero until the first stored word comes back around. When the enable is low, the whole line freezes: there is no write, no pointer movement and no change at the output.

Top module: `ram_delay_line`

## Requirements
- R1: While reset is high at a clock edge, the output becomes zero, the read pointer becomes entry 0 and the write pointer becomes entry D-1, where D = 2^ADDR_W.
- R2: Number the enabled clock edges since reset m = 1, 2, 3 and so on. When m >= D, the output after edge m equals the input word sampled at enabled edge m-D+1, so each word appears D-1 enabled edges after it was taken in.
- R3: After enabled edges m = 1 to D-1, the output is zero, even if the array still holds data from before the reset.
- R4: At a clock edge with enable low, nothing is written, neither pointer moves and the output keeps its value. When enable rises again, the delay sequence continues without loss.
- R5: Both pointers advance by one modulo D on every enabled edge. The write pointer always equals the read pointer minus one, modulo D.
- R6: A reset in the middle of a stream restarts the sequence. The numbering of R2 and R3 begins again from the reset, and words taken in before the reset never reach the output.
- R7: The delay of R2 stays exact across many wraps of the pointers, at least four times around the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, the line holds |
| din | input | DATA_W | Word taken in on an enabled edge |
| dout | output | DATA_W | Registered delayed word |

## Verification
The bench aims first at the priming window: the first D-1 enabled edges after reset, where a design with no gating would show stale or undefined array contents instead of zero. It then mixes random enable gaps with random data. A design that kept writing or moving a pointer while enable was low would shift the stream by one word, and the delay comparison would catch that. A reset in the middle of a stream, with the array full of old words, exposes a design that does not restart priming. Runs longer than several laps catch pointer wrap errors and pointers that start with the wrong offset, which would show up as a delay of D or D-2.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Next pointer value: add one, then wrap modulo 2^aw.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned aw);
    int unsigned mask;
    mask = (32'd1 << aw) - 32'd1;
    return (p + 32'd1) & mask;
  endfunction

  // Entry that trails a given pointer by one location, modulo 2^aw.
  function automatic int unsigned ptr_trail(input int unsigned p, input int unsigned aw);
    int unsigned mask;
    mask = (32'd1 << aw) - 32'd1;
    return (p - 32'd1) & mask;
  endfunction

  // Last entry of an array with 2^aw locations.
  function automatic int unsigned last_entry(input int unsigned aw);
    return (32'd1 << aw) - 32'd1;
  endfunction

endpackage

// File: rtl/dly_ptr_counter.sv
module dly_ptr_counter #(
  parameter int unsigned AW = 4,
  parameter logic [AW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          wrap_o
);
  localparam logic [AW-1:0] TOP = AW'(dly_pkg::last_entry(AW));

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= INIT;
    end else if (step) begin
      ptr_q <= AW'(dly_pkg::ptr_step(32'(ptr_q), AW));
    end
  end

  assign ptr    = ptr_q;
  assign wrap_o = step && (ptr_q == TOP);
endmodule

// File: rtl/dly_store.sv
module dly_store #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          rgate,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] rdata_q;

  // Write port: one word per enabled cycle, with no reset on the array.
  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  // Read port: synchronous and registered. It shows zero until the data is valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= rgate ? cells[raddr] : '0;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dly_prime_tracker.sv
module dly_prime_tracker #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] rd_ptr,
  output logic          lap_done,
  output logic          rd_gate
);
  localparam logic [AW-1:0] TOP = AW'(dly_pkg::last_entry(AW));

  logic filled_q;
  logic at_first_valid;

  // The first word written, at entry D-1, is read when the read pointer reaches D-1.
  assign at_first_valid = (rd_ptr == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      filled_q <= 1'b0;
    end else if (en && at_first_valid) begin
      filled_q <= 1'b1;
    end
  end

  assign lap_done = filled_q;
  assign rd_gate  = filled_q || at_first_valid;
endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam logic [ADDR_W-1:0] RD_START = '0;
  localparam logic [ADDR_W-1:0] WR_START = ADDR_W'(dly_pkg::last_entry(ADDR_W));

  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] wr_ptr;
  logic              wr_fire;
  logic              rd_fire;
  logic              rd_wrap;
  logic              wr_wrap;
  logic              lap_done;
  logic              rd_gate;

  assign wr_fire = en;
  assign rd_fire = en;

  dly_ptr_counter #(.AW(ADDR_W), .INIT(RD_START)) u_rd_ctr (
    .clk(clk), .rst(rst), .step(rd_fire), .ptr(rd_ptr), .wrap_o(rd_wrap)
  );

  dly_ptr_counter #(.AW(ADDR_W), .INIT(WR_START)) u_wr_ctr (
    .clk(clk), .rst(rst), .step(wr_fire), .ptr(wr_ptr), .wrap_o(wr_wrap)
  );

  dly_prime_tracker #(.AW(ADDR_W)) u_prime (
    .clk(clk), .rst(rst), .en(en), .rd_ptr(rd_ptr),
    .lap_done(lap_done), .rd_gate(rd_gate)
  );

  dly_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_fire), .waddr(wr_ptr), .wdata(din),
    .re(rd_fire), .rgate(rd_gate), .raddr(rd_ptr),
    .rdata(dout)
  );
endmodule

// File: rtl/ram_delay_line_chk.sv
module ram_delay_line_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] wr_ptr,
  input logic          rd_wrap,
  input logic          wr_wrap,
  input logic          lap_done,
  input logic [DW-1:0] dout
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rd_ptr == '0 && wr_ptr == '1 && dout == '0 && !lap_done));

  p_zero_priming_r3: assert property (@(posedge clk) disable iff (rst)
    !lap_done |-> dout == '0);

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(rd_ptr) && $stable(wr_ptr)));

  p_ptr_gap_r5: assert property (@(posedge clk) disable iff (rst)
    wr_ptr == AW'(rd_ptr - 1'b1));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    en |=> rd_ptr == AW'($past(rd_ptr) + 1'b1));

  p_wrap_order_r7: assert property (@(posedge clk) disable iff (rst)
    wr_wrap |-> !rd_wrap);
endmodule

bind ram_delay_line ram_delay_line_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
  .rd_wrap(rd_wrap), .wr_wrap(wr_wrap), .lap_done(lap_done), .dout(dout)
);

// File: tb/ram_delay_line_test.sv
module ram_delay_line_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int D  = 1 << AW;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;

  int checks = 0;
  int failures = 0;
  int n_en = 0;
  logic [DW-1:0] hist [HMAX];
  logic [DW-1:0] held;
  bit finished = 0;

  ram_delay_line #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout)
  );

  always #10 clk = ~clk;

  // Expected output after the n-th enabled edge since reset.
  function automatic logic [DW-1:0] expect_out(input int n);
    if (n < D) return '0;
    return hist[n - D];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (enabled edge %0d)", req, act, exp, n_en);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input logic e, input logic [DW-1:0] d, input string req);
    held = dout;
    en = e; din = d;
    @(posedge clk);
    if (e) begin
      hist[n_en] = d;
      n_en++;
    end
    @(negedge clk);
    if (e) check(req, dout, expect_out(n_en));
    else   check("R4 hold", dout, held);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    n_en = 0;
    check("R1 reset output", dout, '0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R3: the priming window outputs zero; the first word returns at edge D (R2).
    for (int i = 0; i < D + 4; i++) step(1'b1, DW'(8'hA0 + i), (i < D - 1) ? "R3 priming" : "R2 delay");
    // R4: a freeze in the middle of the stream, then resume.
    for (int i = 0; i < 5; i++) step(1'b0, DW'(8'h55), "R4");
    for (int i = 0; i < D; i++) step(1'b1, DW'(i * 7), "R4 resume");
    // R6: reset with the array full of old words.
    do_reset();
    for (int i = 0; i < D + 2; i++) step(1'b1, DW'(8'hC0 + i), "R6 restart");
    // R5/R7: random enable and data over many laps.
    void'($urandom(32'd2024));
    for (int i = 0; i < 1500 && n_en < HMAX - 2; i++) begin
      logic e;
      e = ($urandom % 4) != 0;
      step(e, DW'($urandom), "R7 wrap R5 pointers");
    end
    // R2: a single enabled edge after a long pause.
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R4");
    step(1'b1, 8'hFF, "R2 after pause");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule